// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block turns a peripheral clock into a one-cycle tick per baud period for a serial channel. Every stage works synchronously on the peripheral clock and passes single-cycle enables to the next one. No derived clocks are used. The clock first goes through a power-of-two prescaler.

An optional fractional stage can follow the prescaler. It adds a programmable 8-bit step into an 8-bit phase accumulator on each prescaler enable, and its carry-out becomes the enable for the next stage. Over time this passes step/256 of the prescaler enables.

The final stage is an 8-bit reload down-counter. It counts on the selected enable. When it underflows it reloads and emits the tick. A run bit starts and stops the counter. A mode bit turns off the fractional path and stops the timer altogether.

Top module: `baud_tick_gen`

## Requirements
- R1: `baud_tick` is a registered pulse, high for one cycle per counter underflow. With the fractional path off, consecutive ticks are exactly 2^`presc_sel` × (`reload_val`+1) cycles apart.
- R2: The prescaler passes one enable every 2^`presc_sel` cycles, for `presc_sel` from 0 to 7. A value of 0 passes every cycle.
- R3: When `frac_en`=1 and `frac_mode`=0, the counter advances only on the carry-out of the 8-bit sum of the accumulator and `frac_step`, and the accumulator is updated on each prescaler enable. Any 256 consecutive prescaler enables therefore give exactly `frac_step` advances. A step that is a power of two k gives exactly one advance per 256/k enables.
- R4: When `frac_en`=1 and `frac_mode`=0, a `frac_step` of 0 never produces a tick.
- R5: A `reload_val` of 0 gives one tick per counter enable.
- R6: The counter loads `reload_val` on the edge where `run` is first sampled 1 after being 0, and no tick comes from that edge. With `presc_sel`=0 and `frac_en`=0, the first tick is visible after the (`reload_val`+2)-th rising edge, counting the loading edge as the first.
- R7: While `run` is sampled 0, no tick follows.
- R8: When `frac_en`=1 and `frac_mode`=1, the counter is stopped and no tick follows, whatever the value of `run`.
- R9: A synchronous active-high `rst` clears the tick, the prescaler count, the accumulator, the counter and the stored run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Prescaler exponent; divides by 2^value |
| frac_en | input | 1 | Sends the prescaler enable through the fractional stage |
| frac_mode | input | 1 | 0 = fractional mode; 1 = normal divider mode, which stops the counter |
| frac_step | input | 8 | Step added to the phase accumulator |
| reload_val | input | 8 | Value loaded into the down-counter |
| run | input | 1 | Starts (1) or stops (0) the down-counter |
| baud_tick | output | 1 | One-cycle tick per baud period |

## Verification
The hardest property to observe is the exact fractional rate. The carry pattern depends on the accumulator phase left over from earlier settings, so the spacing between two ticks cannot be predicted for an arbitrary step. The stimulus handles this in two ways. It uses power-of-two steps, for which the carry spacing is exact whatever the phase. For other steps it counts ticks over a window of exactly 256 prescaler enables, a window in which the accumulator wraps back to its starting value and the carry count equals the step.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int SEL_W  = 3;
  localparam int DATA_W = 8;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = baud_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             en_out
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    mask   = ~({CW{1'b1}} << sel);
    en_out = ((cnt_q & mask) == mask);
  end
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int ACC_W = baud_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             frac_en,
  input  logic             frac_mode,
  input  logic [ACC_W-1:0] step,
  output logic             en_out,
  output logic             timer_hold
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             adv;

  always_comb begin
    sum        = {1'b0, acc_q} + {1'b0, step};
    adv        = in_en & frac_en & ~frac_mode;
    en_out     = frac_en ? (adv & sum[ACC_W]) : in_en;
    timer_hold = frac_en & frac_mode;
  end

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (adv) acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer #(
  parameter int CNT_W = baud_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             start;
  logic             active;

  always_comb begin
    start  = run & ~run_q;
    active = run & ~hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tick  <= 1'b0;
    end else begin
      run_q <= run;
      tick  <= 1'b0;
      if (start) begin
        cnt_q <= reload;
      end else if (active && step_en) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SEL_W  = baud_pkg::SEL_W,
  parameter int DATA_W = baud_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  presc_sel,
  input  logic              frac_en,
  input  logic              frac_mode,
  input  logic [DATA_W-1:0] frac_step,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              run,
  output logic              baud_tick
);
  logic presc_en;
  logic tmr_en;
  logic tmr_hold;

  baud_prescaler #(.SEL_W(SEL_W)) presc_i (
    .clk(clk), .rst(rst), .sel(presc_sel), .en_out(presc_en)
  );

  baud_frac_div #(.ACC_W(DATA_W)) frac_i (
    .clk(clk), .rst(rst), .in_en(presc_en), .frac_en(frac_en),
    .frac_mode(frac_mode), .step(frac_step),
    .en_out(tmr_en), .timer_hold(tmr_hold)
  );

  baud_reload_timer #(.CNT_W(DATA_W)) tmr_i (
    .clk(clk), .rst(rst), .step_en(tmr_en), .run(run),
    .hold(tmr_hold), .reload(reload_val), .tick(baud_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int SEL_W  = baud_pkg::SEL_W,
  parameter int DATA_W = baud_pkg::DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  presc_sel,
  input logic              frac_en,
  input logic              frac_mode,
  input logic [DATA_W-1:0] frac_step,
  input logic              run,
  input logic              baud_tick
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && presc_sel != '0) |=> !baud_tick); // R1
  AST_ZERO_STEP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (frac_en && !frac_mode && frac_step == '0) |=> !baud_tick); // R4
  AST_LOAD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> !baud_tick); // R6
  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !run |=> !baud_tick); // R7
  AST_NORMAL_MODE_HALT: assert property (@(posedge clk) disable iff (rst)
    (frac_en && frac_mode) |=> !baud_tick); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !baud_tick); // R9
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.SEL_W(SEL_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .presc_sel(presc_sel), .frac_en(frac_en),
  .frac_mode(frac_mode), .frac_step(frac_step), .run(run),
  .baud_tick(baud_tick)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] presc_sel;
  logic       frac_en, frac_mode;
  logic [7:0] frac_step, reload_val;
  logic       run;
  logic       baud_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always #4 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .frac_en(frac_en),
    .frac_mode(frac_mode), .frac_step(frac_step), .reload_val(reload_val),
    .run(run), .baud_tick(baud_tick)
  );

  // {sel[35:33], frac_en[32], step[31:24], reload[23:16], period[15:0]}
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'd0,   8'd9, 16'd10},   // R1
    {3'd1, 1'b0, 8'd0,   8'd3, 16'd8},    // R2
    {3'd3, 1'b0, 8'd0,   8'd4, 16'd40},   // R2
    {3'd2, 1'b0, 8'd0,   8'd0, 16'd4},    // R5
    {3'd7, 1'b0, 8'd0,   8'd1, 16'd256},  // R2
    {3'd0, 1'b1, 8'd128, 8'd0, 16'd2},    // R3
    {3'd0, 1'b1, 8'd64,  8'd2, 16'd12},   // R3
    {3'd1, 1'b1, 8'd32,  8'd1, 16'd32},   // R3
    {3'd2, 1'b1, 8'd16,  8'd0, 16'd64}    // R3
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 5000);
  endtask

  task automatic restart();
    run = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic count_ticks(input int win, output int cnt);
    cnt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (baud_tick) cnt++;
    end
  endtask

  initial begin
    int n, cnt;
    rst = 1'b1; presc_sel = '0; frac_en = 1'b0; frac_mode = 1'b0;
    frac_step = '0; reload_val = '0; run = 1'b1;
    repeat (4) @(negedge clk);
    check(baud_tick == 1'b0, "R9", baud_tick, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      presc_sel  = VEC[v][35:33];
      frac_en    = VEC[v][32];
      frac_step  = VEC[v][31:24];
      reload_val = VEC[v][23:16];
      restart();
      wait_tick(n);
      wait_tick(n);
      wait_tick(n);
      check(n == int'(VEC[v][15:0]), frac_en ? "R3" : "R1", n, int'(VEC[v][15:0]));
    end

    // R6: first tick after load
    presc_sel = 3'd0; frac_en = 1'b0; reload_val = 8'd5;
    run = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!baud_tick && n < 100);
    check(n == 7, "R6", n, 7);

    // R3: non-power-of-two steps over 256 prescaler enables
    frac_en = 1'b1; frac_mode = 1'b0; frac_step = 8'd3; reload_val = 8'd0;
    restart();
    repeat (10) @(negedge clk);
    count_ticks(256, cnt);
    check(cnt == 3, "R3", cnt, 3);
    presc_sel = 3'd1; frac_step = 8'd5;
    repeat (10) @(negedge clk);
    count_ticks(512, cnt);
    check(cnt == 5, "R3", cnt, 5);

    // R4: zero step
    presc_sel = 3'd0; frac_step = 8'd0;
    repeat (2) @(negedge clk);
    count_ticks(300, cnt);
    check(cnt == 0, "R4", cnt, 0);

    // R8: normal divider mode stops the counter
    frac_step = 8'd128; frac_mode = 1'b1;
    restart();
    count_ticks(100, cnt);
    check(cnt == 0, "R8", cnt, 0);

    // R7: run low
    frac_en = 1'b0; frac_mode = 1'b0; run = 1'b0;
    @(negedge clk);
    count_ticks(100, cnt);
    check(cnt == 0, "R7", cnt, 0);

    // R5 / R2: reload 0, no prescale -> tick every cycle
    run = 1'b1;
    repeat (3) @(negedge clk);
    count_ticks(20, cnt);
    check(cnt == 20, "R5", cnt, 20);

    // R9: reset mid-run clears the tick
    rst = 1'b1;
    @(negedge clk);
    check(baud_tick == 1'b0, "R9", baud_tick, 0);
    rst = 1'b0;

    finish_run();
  end
endmodule